// File: doc/BRIEF.md
# Adaptive Transmit Interval Controller

This block sits on the host side of a link to a radio module. It sets the spacing between outbound data messages. A strobe marks the moment each message is due. The host reports the outcome of each hand-off to the radio as either accepted or refused because the radio's buffer was full. At the end of every interval the controller uses the most recent outcome to pick the next spacing. A refusal stretches the interval by a factor of 2^K, capped at a software-set ceiling. An acceptance shrinks it by half. With K at zero the spacing stays fixed.

The interval is counted in whole time units of `TICKS_PER_UNIT` clock cycles. With the default value, one unit is 1 ms at 125 MHz. `TICKS_PER_UNIT` must be at least 2. A small state machine drives the timing. After reset it sits in `ST_WAIT` while a prescaler and a unit down-counter run. The transition `WAIT->FIRE` is taken when the counters expire. `ST_FIRE` lasts one cycle: it raises the strobe, applies the pending outcome and reloads the counters. The transition `FIRE->WAIT` is unconditional. Reset always returns the machine to `ST_WAIT`.

Top module: `tx_pace_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `cur_intv` to 1 and holds `send_stb` low. After reset is released, the first strobe comes exactly `TICKS_PER_UNIT` cycles later.
- R2: `send_stb` is a single-cycle pulse. The distance between consecutive strobes is `N * TICKS_PER_UNIT` cycles, where N is the value `cur_intv` takes right after the first of the two strobes.
- R3: If the pending outcome is a refusal (`res_fail`=1) and `k_exp` is not zero, the next interval is the current one shifted left by `k_exp` bits.
- R4: A grown interval is capped at `max_intv`. This includes shifts whose result does not fit in 16 bits.
- R5: If the pending outcome is an acceptance (`res_fail`=0) and `k_exp` is not zero, the next interval is the current one shifted right by one bit.
- R6: The interval never drops below 1.
- R7: With `k_exp` equal to 0, any outcome leaves the interval unchanged, provided it does not exceed `max_intv`.
- R8: If no outcome is reported during an interval, the interval is unchanged at the next strobe.
- R9: An outcome is applied only at the next strobe. `cur_intv` changes on the cycle after a strobe and at no other time. If several outcomes arrive in one interval, the last one wins. An outcome presented during the strobe cycle itself belongs to the interval that starts with that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | One-cycle report of a hand-off outcome |
| res_fail | input | 1 | Qualifies `res_valid`: 1 means refused (buffer full), 0 means accepted |
| k_exp | input | K_W (4) | Growth exponent K; 0 means fixed spacing |
| max_intv | input | INTV_W (16) | Ceiling on the interval, in units |
| cur_intv | output | INTV_W (16) | Interval in effect, in units |
| send_stb | output | 1 | One-cycle pulse when a message is due |

## Verification
A wrong internal state shows up at the ports in two ways. The strobe spacing is off by the first strobe after the fault. `cur_intv` holds a wrong value on the cycle following that strobe. A stale or dropped pending outcome therefore shows up within one interval. Each check compares `cur_intv` one cycle after a strobe and measures the cycle count between strobes. A counter fault is caught when a single period comes out short or long. A scaling or ordering fault is caught by the interval value.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    // Outcome of the most recent hand-off, held until the next strobe
    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_OK   = 2'd1,
        RES_FAIL = 2'd2
    } res_e;

    // Pacing state machine
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_FIRE = 1'b1
    } pace_state_e;

endpackage

// File: rtl/tpc_result_latch.sv
module tpc_result_latch
    import tpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic res_valid,
    input  logic res_fail,
    input  logic consume,
    output res_e pend_o
);

    res_e pend_q;

    // A new report overrides both older reports and the clear from consume
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= RES_NONE;
        end else if (res_valid) begin
            pend_q <= res_fail ? RES_FAIL : RES_OK;
        end else if (consume) begin
            pend_q <= RES_NONE;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/tpc_scaler.sv
module tpc_scaler
    import tpc_pkg::*;
#(
    parameter int INTV_W = 16,
    parameter int K_W    = 4
) (
    input  logic [INTV_W-1:0] intv_i,
    input  res_e              pend_i,
    input  logic [K_W-1:0]    k_i,
    input  logic [INTV_W-1:0] max_i,
    output logic [INTV_W-1:0] next_o
);

    localparam int SHIFT_MAX = (1 << K_W) - 1;
    localparam int WIDE_W    = INTV_W + SHIFT_MAX;

    logic [WIDE_W-1:0] wide;
    logic [WIDE_W-1:0] max_wide;
    logic [INTV_W-1:0] grown;
    logic [INTV_W-1:0] halved;
    logic [INTV_W-1:0] kept;
    logic [INTV_W-1:0] cand;

    always_comb begin
        // Wide enough that no shift loses bits, so saturation is one compare
        wide     = {{SHIFT_MAX{1'b0}}, intv_i} << k_i;
        max_wide = {{SHIFT_MAX{1'b0}}, max_i};
        grown    = (wide > max_wide) ? max_i : wide[INTV_W-1:0];
        halved   = ((intv_i >> 1) > max_i) ? max_i : (intv_i >> 1);
        kept     = (intv_i > max_i) ? max_i : intv_i;
        cand     = intv_i;
        if (k_i == '0) begin
            if (pend_i != RES_NONE) begin
                cand = kept;
            end
        end else begin
            unique case (pend_i)
                RES_OK:   cand = halved;
                RES_FAIL: cand = grown;
                default:  cand = intv_i;
            endcase
        end
        // Floor at one unit
        next_o = (cand == '0) ? INTV_W'(1) : cand;
    end

endmodule

// File: rtl/tpc_timer.sv
module tpc_timer #(
    parameter int INTV_W         = 16,
    parameter int TICKS_PER_UNIT = 125000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [INTV_W-1:0] units_i,
    output logic              expire_o
);

    localparam int PRE_W = $clog2(TICKS_PER_UNIT);

    logic [PRE_W-1:0]  pre_q;
    logic [INTV_W-1:0] rem_q;

    // The load cycle is the first cycle of the new interval, so the
    // prescaler starts one step short.
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= PRE_W'(TICKS_PER_UNIT - 1);
            rem_q <= '0;
        end else if (load) begin
            pre_q <= PRE_W'(TICKS_PER_UNIT - 2);
            rem_q <= units_i - INTV_W'(1);
        end else if (pre_q == '0) begin
            pre_q <= PRE_W'(TICKS_PER_UNIT - 1);
            if (rem_q != '0) begin
                rem_q <= rem_q - INTV_W'(1);
            end
        end else begin
            pre_q <= pre_q - PRE_W'(1);
        end
    end

    assign expire_o = (pre_q == '0) && (rem_q == '0);

endmodule

// File: rtl/tx_pace_ctrl.sv
module tx_pace_ctrl
    import tpc_pkg::*;
#(
    parameter int INTV_W         = 16,
    parameter int K_W            = 4,
    parameter int TICKS_PER_UNIT = 125000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              res_valid,
    input  logic              res_fail,
    input  logic [K_W-1:0]    k_exp,
    input  logic [INTV_W-1:0] max_intv,
    output logic [INTV_W-1:0] cur_intv,
    output logic              send_stb
);

    pace_state_e       state_q;
    pace_state_e       state_d;
    res_e              pend_q;
    logic              expire;
    logic              fire;
    logic [INTV_W-1:0] intv_q;
    logic [INTV_W-1:0] next_intv;

    tpc_result_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .res_valid (res_valid),
        .res_fail  (res_fail),
        .consume   (fire),
        .pend_o    (pend_q)
    );

    tpc_scaler #(
        .INTV_W (INTV_W),
        .K_W    (K_W)
    ) u_scaler (
        .intv_i (intv_q),
        .pend_i (pend_q),
        .k_i    (k_exp),
        .max_i  (max_intv),
        .next_o (next_intv)
    );

    tpc_timer #(
        .INTV_W         (INTV_W),
        .TICKS_PER_UNIT (TICKS_PER_UNIT)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (fire),
        .units_i  (next_intv),
        .expire_o (expire)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: state_d = expire ? ST_FIRE : ST_WAIT;
            ST_FIRE: state_d = ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    // Outputs
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            ST_FIRE: fire = 1'b1;
            default: fire = 1'b0;
        endcase
    end

    // Interval register
    always_ff @(posedge clk) begin
        if (rst) begin
            intv_q <= INTV_W'(1);
        end else if (fire) begin
            intv_q <= next_intv;
        end
    end

    assign cur_intv = intv_q;
    assign send_stb = fire;

endmodule

// File: rtl/tpc_checker.sv
module tpc_checker
    import tpc_pkg::*;
#(
    parameter int INTV_W = 16,
    parameter int K_W    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              send_stb,
    input logic [INTV_W-1:0] cur_intv,
    input logic [K_W-1:0]    k_exp,
    input logic [INTV_W-1:0] max_intv,
    input res_e              pend
);

    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (cur_intv == INTV_W'(1) && !send_stb)); // R1

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst) send_stb |=> !send_stb); // R2

    AST_GROW_CAPPED: assert property (@(posedge clk) disable iff (rst)
        (send_stb && pend == RES_FAIL && max_intv != '0) |=> cur_intv <= $past(max_intv)); // R4

    AST_HALVE: assert property (@(posedge clk) disable iff (rst)
        (send_stb && pend == RES_OK && k_exp != '0 && cur_intv > INTV_W'(1)
         && (cur_intv >> 1) <= max_intv) |=> cur_intv == ($past(cur_intv) >> 1)); // R5

    AST_NONZERO: assert property (@(posedge clk) disable iff (rst) cur_intv != '0); // R6

    AST_FIXED_K0: assert property (@(posedge clk) disable iff (rst)
        (send_stb && k_exp == '0 && cur_intv <= max_intv) |=> $stable(cur_intv)); // R7

    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (send_stb && pend == RES_NONE) |=> $stable(cur_intv)); // R8

    AST_CHANGE_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
        !send_stb |=> $stable(cur_intv)); // R9

endmodule

bind tx_pace_ctrl tpc_checker #(
    .INTV_W (INTV_W),
    .K_W    (K_W)
) u_tpc_chk (
    .clk      (clk),
    .rst      (rst),
    .send_stb (send_stb),
    .cur_intv (cur_intv),
    .k_exp    (k_exp),
    .max_intv (max_intv),
    .pend     (pend_q)
);

// File: tb/test_tx_pace_ctrl.sv
`timescale 1ns/1ps
module test_tx_pace_ctrl;

    localparam int T = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_valid = 1'b0;
    logic        res_fail = 1'b0;
    logic [3:0]  k_exp = 4'd1;
    logic [15:0] max_intv = 16'd64;
    logic [15:0] cur_intv;
    logic        send_stb;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tx_pace_ctrl #(
        .INTV_W         (16),
        .K_W            (4),
        .TICKS_PER_UNIT (T)
    ) i_tx_pace_ctrl (
        .clk       (clk),
        .rst       (rst),
        .res_valid (res_valid),
        .res_fail  (res_fail),
        .k_exp     (k_exp),
        .max_intv  (max_intv),
        .cur_intv  (cur_intv),
        .send_stb  (send_stb)
    );

    // res: 0 none, 1 accepted, 2 refused; exp: interval after the next strobe
    typedef struct packed {
        logic [1:0]  res;
        logic [3:0]  k;
        logic [15:0] mx;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 4'd1,  16'd64,   16'd2},
        '{2'd2, 4'd1,  16'd64,   16'd4},
        '{2'd1, 4'd1,  16'd64,   16'd2},
        '{2'd2, 4'd4,  16'd64,   16'd32},
        '{2'd2, 4'd4,  16'd64,   16'd64},
        '{2'd1, 4'd4,  16'd64,   16'd32},
        '{2'd1, 4'd4,  16'd64,   16'd16},
        '{2'd0, 4'd4,  16'd64,   16'd16},
        '{2'd2, 4'd0,  16'd64,   16'd16},
        '{2'd1, 4'd0,  16'd64,   16'd16},
        '{2'd1, 4'd6,  16'd64,   16'd8},
        '{2'd1, 4'd6,  16'd64,   16'd4},
        '{2'd1, 4'd6,  16'd64,   16'd2},
        '{2'd1, 4'd6,  16'd64,   16'd1},
        '{2'd1, 4'd6,  16'd64,   16'd1},
        '{2'd2, 4'd8,  16'd100,  16'd100},
        '{2'd1, 4'd1,  16'd100,  16'd50},
        '{2'd2, 4'd1,  16'd30,   16'd30},
        '{2'd2, 4'd8,  16'd1000, 16'd1000},
        '{2'd2, 4'd15, 16'd1000, 16'd1000},
        '{2'd1, 4'd1,  16'd1000, 16'd500}
    };

    function automatic string tag_of(vec_t v);
        if (v.res == 2'd0) return "R8";
        if (v.k == 4'd0) return "R7";
        if (v.res == 2'd2) return (v.exp == v.mx) ? "R4" : "R3";
        return (v.exp == 16'd1) ? "R6" : "R5";
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Counts negedges up to and including the one that sees the strobe
    task automatic wait_stb(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!send_stb);
    endtask

    initial begin
        int n;
        int prev;
        string tag;
        repeat (3) @(negedge clk);
        chk("R1 reset interval", int'(cur_intv), 1);
        chk("R1 strobe low in reset", int'(send_stb), 0);
        rst = 1'b0;
        wait_stb(n);
        chk("R1 first strobe delay", n, T);

        prev = 1;
        tag  = "R1";
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            chk(tag, int'(cur_intv), prev);
            k_exp     = VECS[i].k;
            max_intv  = VECS[i].mx;
            res_valid = (VECS[i].res != 2'd0);
            res_fail  = (VECS[i].res == 2'd2);
            @(negedge clk);
            res_valid = 1'b0;
            wait_stb(n);
            chk("R2 strobe period", n, prev * T - 2);
            prev = int'(VECS[i].exp);
            tag  = tag_of(VECS[i]);
        end
        @(negedge clk);
        chk(tag, int'(cur_intv), prev);

        // R9: the last of several outcomes in one interval wins
        k_exp     = 4'd1;
        max_intv  = 16'd1000;
        res_valid = 1'b1;
        res_fail  = 1'b1;
        @(negedge clk);
        res_fail  = 1'b0;
        @(negedge clk);
        res_valid = 1'b0;
        wait_stb(n);
        @(negedge clk);
        chk("R9 last outcome wins", int'(cur_intv), 250);

        // R9: an outcome presented during the strobe cycle goes to the new interval
        wait_stb(n);
        res_valid = 1'b1;
        res_fail  = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        chk("R9 strobe-cycle outcome not applied yet", int'(cur_intv), 250);
        wait_stb(n);
        chk("R2 period after deferred outcome", n, 250 * T - 1);
        @(negedge clk);
        chk("R9 strobe-cycle outcome applied next", int'(cur_intv), 500);

        // R1: reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 mid-run reset interval", int'(cur_intv), 1);
        chk("R1 mid-run reset strobe", int'(send_stb), 0);
        rst = 1'b0;
        wait_stb(n);
        chk("R1 first strobe after mid-run reset", n, T);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule